// File: doc/BRIEF.md
# Memory Error Status Counter Unit

This block sits next to an ECC-protected RAM and collects what the ECC checker reports. The RAM has two bus masters, a processor (CPU) and a DMA engine. For each master and each direction, read or write, one sticky flag records an uncorrectable error. Software clears these flags one at a time through a write-one-to-clear register.

Corrected read errors from either master go into a 16-bit saturating counter. Each time the counter steps, the new value is compared with a programmable threshold. A match sets a correctable-error flag. The interrupt output is that flag gated by an enable bit. A software write that loads the counter with the threshold value also sets the flag.

Software reaches the block through a simple 32-bit port. Writes are strobed. Reads are combinational on the word address. Register map (word addresses):

| Address | Contents |
|---------|----------|
| 0 | uncorrectable flags, read only |
| 1 | uncorrectable clear |
| 2 | counter |
| 3 | threshold |
| 4 | interrupt enable, bit 0 |
| 5 | correctable flag, bit 0, read only |
| 6 | correctable flag clear, bit 0 |

Top module: `mem_err_status_unit`

## Requirements
- R1: After reset, every flag, the counter, the threshold and the enable are 0, and irq_o is 0.
- R2: A one-cycle pulse on an uncorrectable event input sets its own flag, and the flag stays set. The flags read at address 0 use these bits: bit 3 DMA read, bit 2 CPU read, bit 1 DMA write, bit 0 CPU write.
- R3: Address 1 is the uncorrectable clear. Writing 1 to a bit clears the flag at the same bit position. Writing 0 leaves the flag as it is. Reading address 1 always returns 0.
- R4: If an uncorrectable event and a clear of the same flag land in the same cycle, the flag ends up set.
- R5: The counter is at address 2, bits 15:0, and bits 31:16 read as 0. It rises by 1 for each corrected-error pulse from either master, and software can write it.
- R6: Corrected pulses from both masters in the same cycle raise the counter by 2. A threshold equal to either the first or the second intermediate value counts as a match.
- R7: The counter saturates at 0xFFFF. Further events leave it at 0xFFFF and produce no match.
- R8: The threshold is at address 3, bits 15:0, and resets to 0. A threshold of 0 never matches on an increment.
- R9: A match on an increment sets the correctable flag (address 5, bit 0). irq_o is high only while that flag and the enable (address 4, bit 0) are both 1.
- R10: A software write to the counter with a value equal to the threshold sets the correctable flag. A counter write takes priority over corrected events in the same cycle.
- R11: Writing 1 to bit 0 of address 6 clears the correctable flag, and address 6 reads as 0. If a new match arrives in the same cycle as the clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| ue_cpu_rd_i | input | 1 | Uncorrectable error on a CPU read |
| ue_dma_rd_i | input | 1 | Uncorrectable error on a DMA read |
| ue_cpu_wr_i | input | 1 | Uncorrectable error on a CPU write |
| ue_dma_wr_i | input | 1 | Uncorrectable error on a DMA write |
| ce_cpu_i | input | 1 | Corrected error on a CPU read |
| ce_dma_i | input | 1 | Corrected error on a DMA read |
| irq_o | output | 1 | Correctable-error interrupt |

## Verification
The uncorrectable flags are driven one master and direction at a time and then in mixed groups, so that a swapped bit position or a shared flag shows up. Clears use patterns that mix ones and zeros, and one clear lands on the same cycle as an event, which separates the write-one-to-clear behaviour from a plain overwrite and checks which side wins. The counter is stepped by single pulses and by same-cycle pairs, with the threshold set on the first and then on the second intermediate value, so that a check made only on the final value is caught. Runs near 0xFFFF, a zero threshold, counter loads equal to the threshold, and a load on the same cycle as an event separate saturation, match suppression and write priority.

// File: rtl/mesu_pkg.sv
package mesu_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_UE_FLAG = 3'd0;
  localparam logic [ADDR_W-1:0] A_UE_CLR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT     = 3'd2;
  localparam logic [ADDR_W-1:0] A_THR     = 3'd3;
  localparam logic [ADDR_W-1:0] A_EN      = 3'd4;
  localparam logic [ADDR_W-1:0] A_CE_FLAG = 3'd5;
  localparam logic [ADDR_W-1:0] A_CE_CLR  = 3'd6;
  // uncorrectable flag bit order, decoded by the clear register
  localparam int unsigned UE_CPU_WR = 0;
  localparam int unsigned UE_DMA_WR = 1;
  localparam int unsigned UE_CPU_RD = 2;
  localparam int unsigned UE_DMA_RD = 3;
endpackage

// File: rtl/mesu_ue_flags.sv
module mesu_ue_flags #(
  parameter int unsigned NUM_UE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_UE-1:0] set_i,
  input  logic [NUM_UE-1:0] clr_i,
  output logic [NUM_UE-1:0] flag_o
);
  for (genvar i = 0; i < NUM_UE; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;  // set wins over clear
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/mesu_ce_counter.sv
module mesu_ce_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_cpu_i,
  input  logic             ev_dma_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       n_ev;
  logic [CNT_W-1:0] cnt_d;
  logic             thr_nz;

  assign n_ev   = {1'b0, ev_cpu_i} + {1'b0, ev_dma_i};
  assign thr_nz = |thr_i;

  // step one at a time so every intermediate value is compared
  always_comb begin
    cnt_d = cnt_o;
    hit_o = 1'b0;
    if (wr_i) begin
      cnt_d = wr_val_i;
      hit_o = (wr_val_i == thr_i);
    end else begin
      if (n_ev != 2'd0 && cnt_d != CNT_MAX) begin
        cnt_d = cnt_d + CNT_W'(1);
        if (thr_nz && cnt_d == thr_i) hit_o = 1'b1;
      end
      if (n_ev == 2'd2 && cnt_d != CNT_MAX) begin
        cnt_d = cnt_d + CNT_W'(1);
        if (thr_nz && cnt_d == thr_i) hit_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/mesu_reg_if.sv
module mesu_reg_if
  import mesu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_UE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_UE-1:0] ue_flags_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ce_flag_i,
  output logic [NUM_UE-1:0] ue_clr_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wval_o,
  output logic [CNT_W-1:0]  thr_o,
  output logic              en_o,
  output logic              ce_clr_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  assign ue_clr_o   = (wr_i && addr_i == A_UE_CLR) ? wdata_i[NUM_UE-1:0] : '0;
  assign cnt_wr_o   = wr_i && addr_i == A_CNT;
  assign cnt_wval_o = wdata_i[CNT_W-1:0];
  assign ce_clr_o   = wr_i && addr_i == A_CE_CLR && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o <= '0;
      en_o  <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == A_THR) thr_o <= wdata_i[CNT_W-1:0];
      if (addr_i == A_EN)  en_o  <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_UE_FLAG: rdata_o = DATA_W'(ue_flags_i);
      A_CNT:     rdata_o = DATA_W'(cnt_i);
      A_THR:     rdata_o = DATA_W'(thr_o);
      A_EN:      rdata_o = DATA_W'(en_o);
      A_CE_FLAG: rdata_o = DATA_W'(ce_flag_i);
      default:   rdata_o = '0;  // clear registers and unused words
    endcase
  end
endmodule

// File: rtl/mem_err_status_unit.sv
module mem_err_status_unit
  import mesu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ue_cpu_rd_i,
  input  logic              ue_dma_rd_i,
  input  logic              ue_cpu_wr_i,
  input  logic              ue_dma_wr_i,
  input  logic              ce_cpu_i,
  input  logic              ce_dma_i,
  output logic              irq_o
);
  localparam int unsigned NUM_UE = 4;

  logic [NUM_UE-1:0] ue_evt, ue_clr, ue_flags;
  logic [CNT_W-1:0]  ce_cnt, cnt_wval, thr_q;
  logic              cnt_wr, en_q, ce_clr, ce_hit, ce_flag_q;

  always_comb begin
    ue_evt            = '0;
    ue_evt[UE_CPU_WR] = ue_cpu_wr_i;
    ue_evt[UE_DMA_WR] = ue_dma_wr_i;
    ue_evt[UE_CPU_RD] = ue_cpu_rd_i;
    ue_evt[UE_DMA_RD] = ue_dma_rd_i;
  end

  mesu_reg_if #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_UE(NUM_UE)) u_reg (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ue_flags_i(ue_flags), .cnt_i(ce_cnt), .ce_flag_i(ce_flag_q),
    .ue_clr_o(ue_clr), .cnt_wr_o(cnt_wr), .cnt_wval_o(cnt_wval),
    .thr_o(thr_q), .en_o(en_q), .ce_clr_o(ce_clr)
  );

  mesu_ue_flags #(.NUM_UE(NUM_UE)) u_ue (
    .clk_i, .rst_ni, .set_i(ue_evt), .clr_i(ue_clr), .flag_o(ue_flags)
  );

  mesu_ce_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .ev_cpu_i(ce_cpu_i), .ev_dma_i(ce_dma_i),
    .wr_i(cnt_wr), .wr_val_i(cnt_wval), .thr_i(thr_q),
    .cnt_o(ce_cnt), .hit_o(ce_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ce_flag_q <= 1'b0;
    else if (ce_hit) ce_flag_q <= 1'b1;
    else if (ce_clr) ce_flag_q <= 1'b0;
  end

  assign irq_o = ce_flag_q & en_q;
endmodule

// File: rtl/mesu_chk.sv
module mesu_chk
  import mesu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_UE = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [NUM_UE-1:0] ue_evt,
  input logic [NUM_UE-1:0] ue_flags,
  input logic [CNT_W-1:0]  ce_cnt,
  input logic [CNT_W-1:0]  thr_q,
  input logic              cnt_wr,
  input logic              en_q,
  input logic              ce_clr,
  input logic              ce_flag_q,
  input logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  ue_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_evt != '0 |=> (ue_flags & $past(ue_evt)) == $past(ue_evt));

  // R3
  clr_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_UE_CLR || reg_addr_i == A_CE_CLR) |-> reg_rdata_o == '0);

  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr |=> ce_cnt >= $past(ce_cnt) && (ce_cnt - $past(ce_cnt)) <= CNT_W'(2));

  // R7
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_cnt == CNT_MAX && !cnt_wr) |=> ce_cnt == CNT_MAX);

  // R8
  thr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q == '0 && !ce_flag_q && !cnt_wr) |=> !ce_flag_q);

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_q && ce_flag_q);

  // R11
  ce_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_flag_q && !ce_clr) |=> ce_flag_q);
endmodule

bind mem_err_status_unit mesu_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_UE(NUM_UE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .ue_evt(ue_evt), .ue_flags(ue_flags), .ce_cnt(ce_cnt), .thr_q(thr_q),
  .cnt_wr(cnt_wr), .en_q(en_q), .ce_clr(ce_clr), .ce_flag_q(ce_flag_q), .irq_o(irq_o)
);

// File: tb/tb_mem_err_status_unit.sv
module tb_mem_err_status_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        ue_cpu_rd = 0, ue_dma_rd = 0, ue_cpu_wr = 0, ue_dma_wr = 0;
  logic        ce_cpu = 0, ce_dma = 0, irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_err_status_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ue_cpu_rd_i(ue_cpu_rd), .ue_dma_rd_i(ue_dma_rd),
    .ue_cpu_wr_i(ue_cpu_wr), .ue_dma_wr_i(ue_dma_wr), .ce_cpu_i(ce_cpu),
    .ce_dma_i(ce_dma), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all stimulus applied on a falling edge, held one cycle
  task automatic cycle(bit w, logic [2:0] a, logic [31:0] d, logic [3:0] ue, logic [1:0] ce);
    @(negedge clk);
    wr = w; addr = a; wdata = d;
    {ue_dma_rd, ue_cpu_rd, ue_dma_wr, ue_cpu_wr} = ue;
    {ce_dma, ce_cpu} = ce;
    @(negedge clk);
    wr = 0; wdata = '0;
    {ue_dma_rd, ue_cpu_rd, ue_dma_wr, ue_cpu_wr} = '0;
    {ce_dma, ce_cpu} = '0;
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    cycle(1, a, d, 4'h0, 2'b00);
  endtask

  task automatic rreg(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_reg(string tag, logic [2:0] a, logic [31:0] exp);
    logic [31:0] v;
    rreg(a, v); check(tag, v, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 7; a++) chk_reg("R1 reset reg", 3'(a), 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ue_set;
    cycle(0, 3'd0, 0, 4'b0001, 2'b00); chk_reg("R2 cpu wr flag", 3'd0, 32'h1);
    cycle(0, 3'd0, 0, 4'b1000, 2'b00); chk_reg("R2 dma rd flag", 3'd0, 32'h9);
    cycle(0, 3'd0, 0, 4'b0110, 2'b00); chk_reg("R2 mixed flags", 3'd0, 32'hF);
    cycle(0, 3'd0, 0, 4'b0000, 2'b00); chk_reg("R2 sticky", 3'd0, 32'hF);
  endtask

  task automatic t_ue_clear;
    chk_reg("R3 clear reads 0", 3'd1, 32'h0);
    wreg(3'd1, 32'hFFFF_FFF0); chk_reg("R3 zeros no effect", 3'd0, 32'hF);
    wreg(3'd1, 32'h0000_0005); chk_reg("R3 clear cpu bits", 3'd0, 32'hA);
    chk_reg("R3 clear still 0", 3'd1, 32'h0);
    wreg(3'd1, 32'h0000_0008); chk_reg("R3 clear dma rd", 3'd0, 32'h2);
  endtask

  task automatic t_ue_race;
    cycle(1, 3'd1, 32'hF, 4'b0100, 2'b00);
    chk_reg("R4 set beats clear", 3'd0, 32'h4);
    wreg(3'd1, 32'hF); chk_reg("R4 cleared after", 3'd0, 32'h0);
  endtask

  task automatic t_cnt_basic;
    cycle(0, 3'd0, 0, 4'h0, 2'b01); chk_reg("R5 cpu inc", 3'd2, 32'h1);
    cycle(0, 3'd0, 0, 4'h0, 2'b10); chk_reg("R5 dma inc", 3'd2, 32'h2);
    wreg(3'd2, 32'hABCD_1234);      chk_reg("R5 write, upper 0", 3'd2, 32'h1234);
    chk_reg("R8 thr0 no match", 3'd5, 32'h0);
  endtask

  task automatic t_cnt_dual;
    wreg(3'd3, 32'h5); wreg(3'd2, 32'h4);
    cycle(0, 3'd0, 0, 4'h0, 2'b11);
    chk_reg("R6 +2", 3'd2, 32'h6);
    chk_reg("R6 first intermediate match", 3'd5, 32'h1);
    wreg(3'd6, 32'h1); chk_reg("R11 ce clear", 3'd5, 32'h0);
    chk_reg("R11 clear reads 0", 3'd6, 32'h0);
    wreg(3'd3, 32'h8);
    cycle(0, 3'd0, 0, 4'h0, 2'b11);
    chk_reg("R6 second intermediate match", 3'd5, 32'h1);
    wreg(3'd6, 32'h1);
    wreg(3'd6, 32'h0); chk_reg("R11 write 0 ignored", 3'd5, 32'h0);
  endtask

  task automatic t_cnt_sat;
    wreg(3'd3, 32'hFFFF); wreg(3'd2, 32'hFFFE);
    chk_reg("R10 no match on unequal write", 3'd5, 32'h0);
    cycle(0, 3'd0, 0, 4'h0, 2'b11);
    chk_reg("R7 saturate", 3'd2, 32'hFFFF);
    chk_reg("R7 match at max", 3'd5, 32'h1);
    wreg(3'd6, 32'h1);
    cycle(0, 3'd0, 0, 4'h0, 2'b01);
    chk_reg("R7 stays max", 3'd2, 32'hFFFF);
    chk_reg("R7 no rematch", 3'd5, 32'h0);
  endtask

  task automatic t_thr_zero;
    wreg(3'd3, 32'h0); wreg(3'd2, 32'hFFFD);
    cycle(0, 3'd0, 0, 4'h0, 2'b11);
    cycle(0, 3'd0, 0, 4'h0, 2'b11);
    chk_reg("R8 count", 3'd2, 32'hFFFF);
    chk_reg("R8 thr0 never matches", 3'd5, 32'h0);
  endtask

  task automatic t_wr_match_irq;
    wreg(3'd3, 32'h20);
    wreg(3'd2, 32'h20);
    chk_reg("R10 write match sets flag", 3'd5, 32'h1);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wreg(3'd4, 32'h1); #1;
    check("R9 irq on", {31'b0, irq}, 32'h1);
    wreg(3'd6, 32'h1); #1;
    check("R9 irq off after clear", {31'b0, irq}, 32'h0);
    cycle(1, 3'd2, 32'h10, 4'h0, 2'b11);
    chk_reg("R10 write beats events", 3'd2, 32'h10);
    wreg(3'd2, 32'h1F);
    cycle(1, 3'd6, 32'h1, 4'h0, 2'b01);
    chk_reg("R11 match beats clear", 3'd5, 32'h1);
    #1; check("R9 irq from increment", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ue_set();
    t_ue_clear();
    t_ue_race();
    t_cnt_basic();
    t_cnt_dual();
    t_cnt_sat();
    t_thr_zero();
    t_wr_match_irq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule